// File: doc/BRIEF.md
# Serial-Write Scratchpad with Transfer Status

This block is the staging buffer that sits between a serial command decoder and a memory array. A command strobe captures a 16-bit target address, held as a low byte and a high byte. For a write command, data then arrives one bit per strobe, least significant bit first. Each complete byte is stored in a 64-entry byte buffer. Storage begins at the offset given by the six low address bits and advances by one per byte until the last entry, offset 63, has been filled.

A read-only status byte reports how the last transfer ended. It carries the offset of the last stored byte, a flag that marks an incomplete or untrustworthy buffer, and a flag that marks a finished copy of the buffer into the array. A read port with one cycle of latency lets the downstream copy engine, or a read-back path, fetch buffer contents. A second read-only byte carries hard-wired revision bits.

Top module: `spad_xfer_top`

## Requirements
- R1: A pulse on `cmd_start` loads `tgt_lo`/`tgt_hi` from `addr_lo_in`/`addr_hi_in`, visible after that clock edge. When `cmd_write` is 0 (a read command), the status byte is left unchanged.
- R2: `status_byte` places the ending offset in bits 5..0, the partial flag in bit 6 and the copy-done flag in bit 7. After reset it reads 0x40, and both address bytes read 0x00.
- R3: During a write, bits on `bit_in` qualified by `bit_stb` are assembled least significant bit first. Every eighth bit stores a byte. The first byte goes to offset `addr_lo_in[5:0]`, and each later byte goes to the next offset.
- R4: The ending offset changes on the edge that stores a byte, and it then equals that byte's offset.
- R5: Once offset 63 has been stored, further bits are ignored until the next write command. Buffer contents, the ending offset and the partial flag are all unaffected by them.
- R6: `xfer_end` after a write sets the partial flag if a byte was left incomplete. Otherwise it clears the flag.
- R7: `power_lost` sets the partial flag, and it takes priority over the clearing by `xfer_end` in the same cycle.
- R8: `copy_done` sets the copy-done flag. A write command clears it, and the clear wins when both arrive in the same cycle.
- R9: `version_byte` carries revision bits 7..5 equal to 0 for this revision, and zeros in bits 4..0.
- R10: `rd_data` returns the buffer entry at `rd_addr` one clock after the address is presented.
- R11: Bit strobes while no write is in progress, for example after `xfer_end`, store nothing and leave the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Command strobe, captures the target address |
| cmd_write | input | 1 | With `cmd_start`: 1 = write command, 0 = read command |
| addr_lo_in | input | 8 | Target address bits 7..0 |
| addr_hi_in | input | 8 | Target address bits 15..8 |
| bit_stb | input | 1 | Serial data bit strobe |
| bit_in | input | 1 | Serial data bit |
| xfer_end | input | 1 | End of the current transfer |
| copy_done | input | 1 | Copy of the buffer into the array has finished |
| power_lost | input | 1 | Buffer contents lost to a power event |
| rd_addr | input | 6 | Buffer read offset |
| tgt_lo | output | 8 | Target address low byte |
| tgt_hi | output | 8 | Target address high byte |
| status_byte | output | 8 | {copy-done, partial, ending offset} |
| version_byte | output | 8 | Revision byte |
| rd_data | output | 8 | Buffer entry at the previous `rd_addr` |

## Verification
The write path is tried with several patterns, each separating a different failure:
- A page-aligned run of whole bytes shows the offset sequence and the bit order.
- A start offset of 60 followed by six bytes shows the fill stopping at offset 63 and the overflow bits being ignored.
- A write that ends three bits into a byte separates the set and clear rules of the partial flag.

The flag interplay is tried with power loss, copy completion and write commands in the same cycle, which shows which of the simultaneous events wins. Strobes sent after a transfer has ended, followed by reads of the buffer, show that idle bits are discarded.

// File: rtl/spad_pkg.sv
package spad_pkg;
  typedef enum logic [1:0] {
    FILL_IDLE = 2'd0,
    FILL_RUN  = 2'd1,
    FILL_DONE = 2'd2
  } fill_state_t;
endpackage

// File: rtl/spad_bit_asm.sv
module spad_bit_asm #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              take,
  input  logic              bit_in,
  output logic              commit,
  output logic [BYTE_W-1:0] byte_out,
  output logic              frag
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;

  // LSB-first: each new bit enters at the top and slides down.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (take) begin
      sh_q  <= {bit_in, sh_q[BYTE_W-1:1]};
      cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_comb begin
    commit   = take && (cnt_q == CNT_LAST);
    byte_out = {bit_in, sh_q[BYTE_W-1:1]};
    frag     = (cnt_q != '0);
  end

  // R3: a stored byte always resets the bit count
  a_r3_count_wraps: assert property (@(posedge clk) disable iff (rst)
    (commit && !clear) |=> !frag);
endmodule

// File: rtl/spad_mem.sv
module spad_mem #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spad_status.sv
module spad_status
  import spad_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned OFF_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_start,
  input  logic [OFF_W-1:0] start_off,
  input  logic             commit,
  input  logic             frag,
  input  logic             xfer_end,
  input  logic             copy_pulse,
  input  logic             pwr_loss,
  output logic             accept,
  output logic [OFF_W-1:0] wptr,
  output logic [OFF_W-1:0] end_off,
  output logic             partial,
  output logic             copied
);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(DEPTH - 1);

  fill_state_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= FILL_IDLE;
      wptr    <= '0;
      end_off <= '0;
    end else if (wr_start) begin
      st_q <= FILL_RUN;
      wptr <= start_off;
    end else begin
      if (commit) begin
        end_off <= wptr;
        if (wptr == OFF_LAST) st_q <= FILL_DONE;
        else                  wptr <= wptr + 1'b1;
      end
      if (xfer_end) st_q <= FILL_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      partial <= 1'b1;
    end else if (pwr_loss) begin
      partial <= 1'b1;
    end else if (xfer_end && st_q != FILL_IDLE) begin
      partial <= frag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             copied <= 1'b0;
    else if (wr_start)   copied <= 1'b0;
    else if (copy_pulse) copied <= 1'b1;
  end

  assign accept = (st_q == FILL_RUN);

  // R8: a write command always leaves the copy flag clear
  a_r8_write_clears_copy: assert property (@(posedge clk) disable iff (rst)
    wr_start |=> !copied);
  // R7: power loss always marks the buffer partial
  a_r7_power_sets_partial: assert property (@(posedge clk) disable iff (rst)
    pwr_loss |=> partial);
  // R5: once the buffer is full the ending offset is frozen
  a_r5_full_freezes_offset: assert property (@(posedge clk) disable iff (rst)
    (st_q == FILL_DONE) |=> $stable(end_off));
  // R6: an incomplete byte at end of write sets the flag
  a_r6_fragment_sets_partial: assert property (@(posedge clk) disable iff (rst)
    (xfer_end && accept && frag && !wr_start) |=> partial);
endmodule

// File: rtl/spad_xfer_top.sv
module spad_xfer_top #(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned REV_W   = 3,
  parameter int unsigned REV_VAL = 0,
  localparam int unsigned OFF_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              cmd_write,
  input  logic [BYTE_W-1:0] addr_lo_in,
  input  logic [BYTE_W-1:0] addr_hi_in,
  input  logic              bit_stb,
  input  logic              bit_in,
  input  logic              xfer_end,
  input  logic              copy_done,
  input  logic              power_lost,
  input  logic [OFF_W-1:0]  rd_addr,
  output logic [BYTE_W-1:0] tgt_lo,
  output logic [BYTE_W-1:0] tgt_hi,
  output logic [BYTE_W-1:0] status_byte,
  output logic [BYTE_W-1:0] version_byte,
  output logic [BYTE_W-1:0] rd_data
);
  logic              wr_start, accept, take, commit, frag, partial, copied;
  logic [OFF_W-1:0]  wptr, end_off;
  logic [BYTE_W-1:0] new_byte;

  assign wr_start = cmd_start && cmd_write;
  assign take     = bit_stb && accept && !cmd_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_lo <= '0;
      tgt_hi <= '0;
    end else if (cmd_start) begin
      tgt_lo <= addr_lo_in;
      tgt_hi <= addr_hi_in;
    end
  end

  spad_bit_asm #(.BYTE_W(BYTE_W)) i_asm (
    .clk(clk), .rst(rst), .clear(wr_start), .take(take), .bit_in(bit_in),
    .commit(commit), .byte_out(new_byte), .frag(frag)
  );

  spad_status #(.DEPTH(DEPTH)) i_stat (
    .clk(clk), .rst(rst), .wr_start(wr_start), .start_off(addr_lo_in[OFF_W-1:0]),
    .commit(commit), .frag(frag), .xfer_end(xfer_end), .copy_pulse(copy_done),
    .pwr_loss(power_lost), .accept(accept), .wptr(wptr), .end_off(end_off),
    .partial(partial), .copied(copied)
  );

  spad_mem #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) i_mem (
    .clk(clk), .we(commit), .waddr(wptr), .wdata(new_byte),
    .raddr(rd_addr), .rdata(rd_data)
  );

  always_comb begin
    status_byte = '0;
    status_byte[OFF_W-1:0] = end_off;
    status_byte[OFF_W]     = partial;
    status_byte[OFF_W+1]   = copied;
  end

  localparam logic [REV_W-1:0] REV_BITS = REV_W'(REV_VAL);
  for (genvar g = 0; g < BYTE_W; g++) begin : g_ver
    if (g >= BYTE_W - REV_W) begin : g_rev
      assign version_byte[g] = REV_BITS[g - (BYTE_W - REV_W)];
    end else begin : g_zero
      assign version_byte[g] = 1'b0;
    end
  end

  // R11: idle strobes never write the buffer
  a_r11_idle_no_store: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && !accept) |-> !commit);
  // R1: a read command leaves the status byte untouched
  a_r1_read_keeps_status: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && !cmd_write && !bit_stb && !xfer_end && !copy_done && !power_lost)
      |=> $stable(status_byte));
endmodule

// File: tb/test_spad_xfer_top.sv
`timescale 1ns/1ps
module test_spad_xfer_top;
  logic clk = 1'b0, rst = 1'b1;
  logic cmd_start = 0, cmd_write = 0, bit_stb = 0, bit_in = 0;
  logic xfer_end = 0, copy_done = 0, power_lost = 0;
  logic [7:0] addr_lo_in = 0, addr_hi_in = 0;
  logic [5:0] rd_addr = 0;
  logic [7:0] tgt_lo, tgt_hi, status_byte, version_byte, rd_data;

  always #2 clk = ~clk;

  spad_xfer_top i_spad_xfer_top (.*);

  int errors = 0, checks = 0;
  bit finished = 0;

  // behavioural reference
  int m_lo = 0, m_hi = 0, m_mode = 0, m_ptr = 0, m_cnt = 0, m_end = 0;
  int m_pf = 1, m_aa = 0, m_sh = 0, m_rd = -1;
  int m_mem [64];
  bit m_ok [64];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    int rd_next;
    rd_next = m_ok[rd_addr] ? m_mem[rd_addr] : -1;
    if (cmd_start) begin
      m_lo = addr_lo_in; m_hi = addr_hi_in;
      if (cmd_write) begin
        m_mode = 1; m_ptr = addr_lo_in % 64; m_cnt = 0; m_aa = 0;
      end
    end else begin
      if (bit_stb && m_mode == 1) begin
        m_sh = (m_sh >> 1) | (bit_in << 7);
        m_cnt++;
        if (m_cnt == 8) begin
          m_cnt = 0; m_mem[m_ptr] = m_sh; m_ok[m_ptr] = 1; m_end = m_ptr;
          if (m_ptr == 63) m_mode = 2; else m_ptr++;
        end
      end
      if (copy_done) m_aa = 1;
    end
    if (power_lost) m_pf = 1;
    else if (xfer_end && m_mode != 0) m_pf = (m_cnt != 0);
    if (xfer_end && !cmd_start) m_mode = 0;
    m_rd = rd_next;
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rst) model_edge();
    @(negedge clk);
    if (!rst) begin
      chk("R1 tgt_lo", tgt_lo, m_lo);
      chk("R1 tgt_hi", tgt_hi, m_hi);
      chk("R4 ending offset", status_byte[5:0], m_end);
      chk("R6 partial flag", status_byte[6], m_pf);
      chk("R8 copy flag", status_byte[7], m_aa);
      if (m_rd >= 0) chk("R10 rd_data", rd_data, m_rd);
    end
    cmd_start = 0; cmd_write = 0; bit_stb = 0; xfer_end = 0;
    copy_done = 0; power_lost = 0;
  endtask

  task automatic start(bit wr, int addr);
    cmd_start = 1; cmd_write = wr; addr_lo_in = addr[7:0]; addr_hi_in = addr[15:8];
    tick();
  endtask

  task automatic send_bits(int val, int n);
    for (int i = 0; i < n; i++) begin
      bit_stb = 1; bit_in = val[i]; tick();
    end
  endtask

  task automatic finish_xfer();
    xfer_end = 1; tick();
  endtask

  task automatic readback(int off, int exp, string req);
    rd_addr = off[5:0]; tick();
    chk(req, rd_data, exp);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin m_mem[i] = 0; m_ok[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R2 reset status", status_byte, 8'h40);
    chk("R2 reset tgt_lo", tgt_lo, 0);
    chk("R2 reset tgt_hi", tgt_hi, 0);
    chk("R9 version", version_byte, 8'h00);

    // R3: page-aligned whole bytes
    start(1, 16'h1000);
    send_bits(8'hA5, 8); send_bits(8'h3C, 8); send_bits(8'h81, 8);
    finish_xfer();
    chk("R2 status after aligned write", status_byte, 8'h02);
    readback(0, 8'hA5, "R3 byte0"); readback(1, 8'h3C, "R3 byte1");
    readback(2, 8'h81, "R3 byte2");

    // R5: start at 3C, six bytes, last two ignored
    start(1, 16'h103C);
    for (int b = 0; b < 6; b++) send_bits(8'h10 + b, 8);
    send_bits(8'h07, 3);
    finish_xfer();
    chk("R5 full ending offset", status_byte[5:0], 6'h3F);
    chk("R5 full partial clear", status_byte[6], 0);
    readback(6'h3F, 8'h13, "R5 last slot keeps byte 3");
    readback(0, 8'hA5, "R5 no wrap to offset 0");

    // R6: incomplete byte
    start(1, 16'h0005);
    send_bits(8'h5A, 8); send_bits(8'h05, 3);
    finish_xfer();
    chk("R6 partial set", status_byte, 8'h45);
    readback(5, 8'h5A, "R3 byte at offset 5");

    // R11: idle strobes
    send_bits(8'hFF, 8);
    chk("R11 idle status", status_byte, 8'h45);
    readback(6, m_ok[6] ? m_mem[6] : 0, "R11 idle no store");

    // R8 / R1
    copy_done = 1; tick();
    chk("R8 copy set", status_byte[7], 1);
    start(0, 16'h2233);
    chk("R1 read keeps status", status_byte, 8'hC5);
    cmd_start = 1; cmd_write = 1; copy_done = 1; addr_lo_in = 8'h20; tick();
    chk("R8 clear wins", status_byte[7], 0);
    send_bits(8'h77, 8);
    finish_xfer();
    chk("R6 valid write clears", status_byte, 8'h20);

    // R7
    power_lost = 1; tick();
    chk("R7 power sets", status_byte[6], 1);
    start(1, 16'h0010);
    send_bits(8'h99, 8);
    xfer_end = 1; power_lost = 1; tick();
    chk("R7 power wins over end", status_byte[6], 1);

    repeat (3) tick();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule